// File: doc/BRIEF.md
# Memory Test Control Register File

This block is the software-facing side of a memory tester. A simple 32-bit register port lets software set the address window, the data pattern, the burst size and the pass direction. Software then launches an operation by writing the configuration word with a pattern-select bit set. The block passes these settings to a separate test engine, which generates the memory traffic. It also gives the engine a single-cycle start pulse.

While the engine works, the block measures the operation in clock cycles and counts the data mismatches the engine reports. When the engine drops busy, software reads back the cycle count, the mismatch count, the current pointer and the last word read. From these it can derive bandwidth and judge pass or fail.

Register reads have one cycle of latency. The word offsets are: 0x00 configuration, 0x04 window start, 0x08 window end, 0x0C status, 0x10 current pointer, 0x14 user word, 0x18 elapsed cycles, 0x1C mismatch count, 0x20 last read word. The address bits below the word offset are ignored.

Top module: `memtest_regs`

## Requirements
- R1: After reset, every readable register returns zero, `eng_start` is low and `eng_mode` is 0.
- R2: A write to offset 0x00 with any of data bits 3..0 set, while the status busy bit is 0, raises `eng_start` for exactly one cycle, in the cycle after the write.
- R3: A write to offset 0x00 made while the status busy bit is 1 is ignored: there is no start pulse and the configuration readback is unchanged. A write to offset 0x00 with bits 3..0 all clear stores the word but gives no start pulse.
- R4: At a launch, `eng_mode` takes the highest selected pattern, in the priority bit 3 (user, code 3), then bit 2 (incrementing, code 2), then bit 1 (all ones, code 1), then bit 0 (all zeros, code 0).
- R5: Configuration bits 31..28 drive `eng_burst_m1`, bit 8 drives `eng_read` and bit 7 drives `eng_rnd_delay`. Readback of offset 0x00 returns bits 31..28, 8, 7 and 3..0 as written, with all other bits zero.
- R6: The window start (0x04) is stored with bits 1..0 forced to zero. The window end (0x08) and the user word (0x14) are stored in full. All three appear on their engine outputs.
- R7: Status bit 0 (0x0C) reads 1 while `eng_busy` is high or a start pulse is pending. All other status bits read 0.
- R8: The elapsed-cycle register (0x18) clears at the start pulse. It then adds one on every clock with `eng_busy` high, until `eng_done` has been seen. After that it holds until the next start.
- R9: The mismatch register (0x1C) clears at the start pulse. It adds one on every clock with both `eng_mismatch` and `eng_busy` high.
- R10: Offsets 0x10 and 0x20 return the engine's current pointer and last read word.
- R11: Read data appears one cycle after the read strobe. Offsets above 0x20 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_mode | output | 2 | Pattern code: 0 zeros, 1 ones, 2 incrementing, 3 user |
| eng_read | output | 1 | Read-and-compare pass when 1, write pass when 0 |
| eng_rnd_delay | output | 1 | Enable for pseudo-random gaps between accesses |
| eng_burst_m1 | output | 4 | Burst length minus one |
| eng_base | output | 32 | Window start, word aligned |
| eng_end | output | 32 | Window end (exclusive) |
| eng_pattern | output | 32 | User data word |
| eng_busy | input | 1 | Engine is running an operation |
| eng_done | input | 1 | Engine finished its operation |
| eng_mismatch | input | 1 | Engine saw a compare mismatch this cycle |
| eng_cur_addr | input | 32 | Engine's current address |
| eng_last_rd | input | 32 | Last word the engine read back |

## Verification
The assertions check, on every cycle, the following:
- the start pulse lasts one cycle and is caused by an idle configuration write with a select bit set;
- the pattern-priority result at launch;
- the clearing of both counters right after a start;
- that both counters hold while the engine is idle;
- that unmapped reads return zero.

Only the bench's scenarios show the rest:
- the exact elapsed-cycle and mismatch totals of whole operations;
- the freeze of the timer after done, even when busy returns;
- that an ignored write leaves the readback unchanged;
- alignment of the window start;
- readback of every field.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned BURST_W = 4;
  localparam int unsigned EXEC_W  = 4;

  // word indices (byte offset / 4)
  localparam int unsigned WIDX_CFG   = 0;
  localparam int unsigned WIDX_BASE  = 1;
  localparam int unsigned WIDX_END   = 2;
  localparam int unsigned WIDX_STAT  = 3;
  localparam int unsigned WIDX_CUR   = 4;
  localparam int unsigned WIDX_PAT   = 5;
  localparam int unsigned WIDX_CYC   = 6;
  localparam int unsigned WIDX_ERR   = 7;
  localparam int unsigned WIDX_LAST  = 8;
  localparam int unsigned N_WORDS    = 9;

  // configuration bit positions
  localparam int unsigned CFG_READ_BIT = 8;
  localparam int unsigned CFG_RND_BIT  = 7;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_ONES = 2'd1,
    MODE_INCR = 2'd2,
    MODE_USER = 2'd3
  } pat_mode_e;

  function automatic pat_mode_e pick_mode(input logic [EXEC_W-1:0] sel);
    if (sel[3])      return MODE_USER;
    else if (sel[2]) return MODE_INCR;
    else if (sel[1]) return MODE_ONES;
    else             return MODE_ZERO;
  endfunction

endpackage

// File: rtl/memtest_cfg_regs.sv
module memtest_cfg_regs
  import memtest_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               eng_busy,
  output logic [REG_W-1:0]   cfg_word,
  output logic [REG_W-1:0]   base_q,
  output logic [REG_W-1:0]   end_q,
  output logic [REG_W-1:0]   pat_q,
  output logic [BURST_W-1:0] burst_q,
  output logic               read_q,
  output logic               rnd_q,
  output pat_mode_e          mode_q,
  output logic               start_q
);

  localparam int unsigned GAP_HI = REG_W - BURST_W - CFG_READ_BIT - 1;
  localparam int unsigned GAP_LO = CFG_RND_BIT - EXEC_W;

  logic [EXEC_W-1:0] exec_q;
  logic              blocked;
  logic              is_cfg;

  assign blocked = eng_busy | start_q;
  assign is_cfg  = wr_en && (wr_idx == IDX_W'(WIDX_CFG));

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_q  <= '0;
      burst_q <= '0;
      read_q  <= 1'b0;
      rnd_q   <= 1'b0;
      mode_q  <= MODE_ZERO;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (is_cfg && !blocked) begin
        exec_q  <= wr_data[EXEC_W-1:0];
        burst_q <= wr_data[REG_W-1 -: BURST_W];
        read_q  <= wr_data[CFG_READ_BIT];
        rnd_q   <= wr_data[CFG_RND_BIT];
        if (|wr_data[EXEC_W-1:0]) begin
          start_q <= 1'b1;
          mode_q  <= pick_mode(wr_data[EXEC_W-1:0]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      end_q  <= '0;
      pat_q  <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(WIDX_BASE)) base_q <= {wr_data[REG_W-1:2], 2'b00};
      if (wr_idx == IDX_W'(WIDX_END))  end_q  <= wr_data;
      if (wr_idx == IDX_W'(WIDX_PAT))  pat_q  <= wr_data;
    end
  end

  assign cfg_word = {burst_q, {GAP_HI{1'b0}}, read_q, rnd_q, {GAP_LO{1'b0}}, exec_q};

endmodule

// File: rtl/memtest_op_stats.sv
module memtest_op_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic             done,
  input  logic             mismatch,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] err_cnt
);

  logic frozen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt  <= '0;
      err_cnt  <= '0;
      frozen_q <= 1'b0;
    end else if (start) begin
      cyc_cnt  <= '0;
      err_cnt  <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (done) frozen_q <= 1'b1;
      if (busy && !frozen_q) cyc_cnt <= cyc_cnt + CNT_W'(1);
      if (busy && mismatch)  err_cnt <= err_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/memtest_rd_mux.sv
module memtest_rd_mux
  import memtest_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [REG_W-1:0] words [N_WORDS],
  output logic [REG_W-1:0] rd_data
);

  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(N_WORDS); i++) begin
      if (rd_idx == IDX_W'(i)) sel = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end

endmodule

// File: rtl/memtest_regs.sv
module memtest_regs
  import memtest_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                eng_start,
  output logic [1:0]          eng_mode,
  output logic                eng_read,
  output logic                eng_rnd_delay,
  output logic [BURST_W-1:0]  eng_burst_m1,
  output logic [REG_W-1:0]    eng_base,
  output logic [REG_W-1:0]    eng_end,
  output logic [REG_W-1:0]    eng_pattern,
  input  logic                eng_busy,
  input  logic                eng_done,
  input  logic                eng_mismatch,
  input  logic [REG_W-1:0]    eng_cur_addr,
  input  logic [REG_W-1:0]    eng_last_rd
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             unused_lo;
  logic [REG_W-1:0] cfg_word;
  pat_mode_e        mode_q;
  logic [CNT_W-1:0] cyc_cnt;
  logic [CNT_W-1:0] err_cnt;
  logic [REG_W-1:0] words [N_WORDS];

  assign widx      = reg_addr[ADDR_W-1:2];
  assign unused_lo = ^reg_addr[1:0];

  memtest_cfg_regs #(.IDX_W(IDX_W)) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_idx   (widx),
    .wr_data  (reg_wdata),
    .eng_busy (eng_busy),
    .cfg_word (cfg_word),
    .base_q   (eng_base),
    .end_q    (eng_end),
    .pat_q    (eng_pattern),
    .burst_q  (eng_burst_m1),
    .read_q   (eng_read),
    .rnd_q    (eng_rnd_delay),
    .mode_q   (mode_q),
    .start_q  (eng_start)
  );

  assign eng_mode = mode_q;

  memtest_op_stats #(.CNT_W(CNT_W)) stats_i (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .busy     (eng_busy),
    .done     (eng_done),
    .mismatch (eng_mismatch),
    .cyc_cnt  (cyc_cnt),
    .err_cnt  (err_cnt)
  );

  always_comb begin
    words[WIDX_CFG]  = cfg_word;
    words[WIDX_BASE] = eng_base;
    words[WIDX_END]  = eng_end;
    words[WIDX_STAT] = {{(REG_W-1){1'b0}}, eng_busy | eng_start};
    words[WIDX_CUR]  = eng_cur_addr;
    words[WIDX_PAT]  = eng_pattern;
    words[WIDX_CYC]  = REG_W'(cyc_cnt);
    words[WIDX_ERR]  = REG_W'(err_cnt);
    words[WIDX_LAST] = eng_last_rd;
  end

  memtest_rd_mux #(.IDX_W(IDX_W)) rdmux_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd_en),
    .rd_idx  (widx),
    .words   (words),
    .rd_data (reg_rdata)
  );

endmodule

// File: rtl/memtest_regs_sva.sv
module memtest_regs_sva #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              eng_start,
  input logic [1:0]        eng_mode,
  input logic              eng_busy,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [CNT_W-1:0]  err_cnt
);

  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(reg_wr_en && reg_addr[ADDR_W-1:2] == '0 && |reg_wdata[3:0]));

  p_start_idle_r3: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(!eng_busy));

  p_mode_user_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_start && $past(reg_wdata[3])) |-> eng_mode == 2'd3);

  p_mode_incr_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_start && $past(reg_wdata[3:2] == 2'b01)) |-> eng_mode == 2'd2);

  p_mode_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_start && $past(reg_wdata[3:1] == 3'b001)) |-> eng_mode == 2'd1);

  p_clear_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> (cyc_cnt == '0 && err_cnt == '0));

  p_timer_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && !eng_start) |=> $stable(cyc_cnt));

  p_errors_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && !eng_start) |=> $stable(err_cnt));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr[ADDR_W-1:2] > (ADDR_W-2)'(8)) |=> reg_rdata == '0);

endmodule

bind memtest_regs memtest_regs_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) sva_i (
  .clk       (clk),
  .rst       (rst),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .eng_start (eng_start),
  .eng_mode  (eng_mode),
  .eng_busy  (eng_busy),
  .cyc_cnt   (cyc_cnt),
  .err_cnt   (err_cnt)
);

// File: tb/memtest_regs_tb.sv
module memtest_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  localparam logic [7:0] A_CFG  = 8'h00, A_BASE = 8'h04, A_END  = 8'h08,
                         A_STAT = 8'h0C, A_CUR  = 8'h10, A_PAT  = 8'h14,
                         A_CYC  = 8'h18, A_ERR  = 8'h1C, A_LAST = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_read, eng_rnd_delay;
  logic [1:0]  eng_mode;
  logic [3:0]  eng_burst_m1;
  logic [31:0] eng_base, eng_end, eng_pattern;
  logic        eng_busy = 1'b0, eng_done = 1'b0, eng_mismatch = 1'b0;
  logic [31:0] eng_cur_addr = '0, eng_last_rd = '0;

  int checks = 0;
  int failures = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_fire = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memtest_regs #(.ADDR_W(ADDR_W), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_mode(eng_mode), .eng_read(eng_read),
    .eng_rnd_delay(eng_rnd_delay), .eng_burst_m1(eng_burst_m1),
    .eng_base(eng_base), .eng_end(eng_end), .eng_pattern(eng_pattern),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_mismatch(eng_mismatch),
    .eng_cur_addr(eng_cur_addr), .eng_last_rd(eng_last_rd)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read strobe
  always @(posedge clk) rd_fire <= reg_rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic eng_begin();
    @(negedge clk);          // let the start edge pass
    eng_busy = 1'b1;
  endtask

  task automatic eng_finish();
    eng_busy = 1'b0; eng_mismatch = 1'b0; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk({31'b0, eng_start}, 32'h0, "R1 start after reset");
    chk({30'b0, eng_mode}, 32'h0, "R1 mode after reset");
    reg_read(A_CFG,  32'h0, "R1 cfg reset");
    reg_read(A_BASE, 32'h0, "R1 base reset");
    reg_read(A_END,  32'h0, "R1 end reset");
    reg_read(A_STAT, 32'h0, "R1 status reset");
    reg_read(A_PAT,  32'h0, "R1 pattern reset");
    reg_read(A_CYC,  32'h0, "R1 cycles reset");
    reg_read(A_ERR,  32'h0, "R1 errors reset");

    // R6 window and pattern
    reg_write(A_BASE, 32'h8000_0003);
    reg_write(A_END,  32'h8000_0101);
    reg_write(A_PAT,  32'h5555_AAAA);
    chk(eng_base, 32'h8000_0000, "R6 base aligned at port");
    chk(eng_end, 32'h8000_0101, "R6 end at port");
    chk(eng_pattern, 32'h5555_AAAA, "R6 pattern at port");
    reg_read(A_BASE, 32'h8000_0000, "R6 base readback");
    reg_read(A_END,  32'h8000_0101, "R6 end readback");
    reg_read(A_PAT,  32'h5555_AAAA, "R6 pattern readback");

    // R3 / R5 config store without launch
    reg_write(A_CFG, 32'h3FFF_FF80 | 32'h0000_0100);
    chk({31'b0, eng_start}, 32'h0, "R3 no start without select bits");
    @(negedge clk);
    chk({31'b0, eng_start}, 32'h0, "R3 still no start");
    chk({28'b0, eng_burst_m1}, 32'h3, "R5 burst field");
    chk({31'b0, eng_read}, 32'h1, "R5 read bit");
    chk({31'b0, eng_rnd_delay}, 32'h1, "R5 random delay bit");
    reg_read(A_CFG, 32'h3000_0180, "R5 cfg readback masked");

    // R2 / R4 launch with user and incrementing selected
    reg_write(A_CFG, 32'h1000_000C);
    chk({31'b0, eng_start}, 32'h1, "R2 start pulse");
    chk({30'b0, eng_mode}, 32'h3, "R4 user wins");
    reg_read(A_STAT, 32'h1, "R7 status busy while start pending");
    chk({31'b0, eng_start}, 32'h0, "R2 start lasts one cycle");
    eng_busy = 1'b1;
    // R8 / R9 busy phase: 7 counted edges, 2 mismatches
    eng_mismatch = 1'b1; idle(1);
    eng_mismatch = 1'b0; idle(1);
    eng_mismatch = 1'b1; idle(1);
    eng_mismatch = 1'b0;
    reg_write(A_CFG, 32'h0000_0001);
    chk({31'b0, eng_start}, 32'h0, "R3 write while busy gives no start");
    reg_read(A_STAT, 32'h1, "R7 status busy");
    reg_read(A_CFG, 32'h1000_000C, "R3 cfg unchanged after busy write");
    idle(1);
    eng_finish();
    reg_read(A_STAT, 32'h0, "R7 status idle after done");
    reg_read(A_CYC, 32'd7, "R8 cycle total");
    reg_read(A_ERR, 32'd2, "R9 mismatch total");
    // R8 freeze: busy returns without a start
    eng_busy = 1'b1; idle(3); eng_busy = 1'b0;
    reg_read(A_CYC, 32'd7, "R8 timer frozen after done");

    // R4 incrementing; R9 errors clear at start
    reg_write(A_CFG, 32'h0000_0006);
    chk({30'b0, eng_mode}, 32'h2, "R4 incrementing beats ones");
    eng_begin(); idle(4); eng_finish();
    reg_read(A_CYC, 32'd4, "R8 short run");
    reg_read(A_ERR, 32'd0, "R9 errors cleared at start");
    reg_read(A_CFG, 32'h0000_0006, "R5 cfg readback after launch");

    // R4 ones, then zeros with empty busy phase
    reg_write(A_CFG, 32'h0000_0003);
    chk({30'b0, eng_mode}, 32'h1, "R4 ones beats zeros");
    eng_begin(); idle(2); eng_finish();
    reg_read(A_CYC, 32'd2, "R8 two-cycle run");
    reg_write(A_CFG, 32'h0000_0001);
    chk({30'b0, eng_mode}, 32'h0, "R4 zeros alone");
    @(negedge clk);
    eng_finish();
    reg_read(A_CYC, 32'd0, "R8 zero-cycle run");

    // R10 engine passthrough
    eng_cur_addr = 32'h8000_0040;
    eng_last_rd  = 32'hDEAD_BEEF;
    reg_read(A_CUR,  32'h8000_0040, "R10 current pointer");
    reg_read(A_LAST, 32'hDEAD_BEEF, "R10 last read word");

    // R11 unmapped offsets
    reg_read(8'h24, 32'h0, "R11 offset 0x24");
    reg_read(8'h3C, 32'h0, "R11 offset 0x3C");
    reg_read(8'hFC, 32'h0, "R11 offset 0xFC");
    reg_read(A_PAT + 8'h2, 32'h5555_AAAA, "R11 low address bits ignored");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 reads left unanswered actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule